// File: doc/BRIEF.md
# Interrupt Acknowledge and Activation Unit

This unit serves one CPU's read of the interrupt acknowledge register. An upstream selector presents the ID of the best pending interrupt. When the CPU strobes an acknowledge, the unit decides whether that interrupt may be taken. If it may, the unit returns its ID and marks it active. If it may not, the unit returns the spurious ID 1023. The answer appears one clock after the strobe, together with single-cycle strobes that tell the pending and active state holders what to change.

On activation the unit masks the interrupt's priority with a binary point to form a group priority. That value becomes the new running priority. One bit is also set in a secure or non-secure active-priority bank. For the software-generated interrupts (IDs below 16), the unit keeps a mask of the CPUs that raised each one. It acknowledges them one source at a time, lowest source first, and reports the source number in the returned value. End-of-interrupt handling and register decoding belong to neighbouring blocks.

The control path is a three-state machine:
- `ST_IDLE`: no response.
- `ST_GRANT`: the acknowledge was accepted.
- `ST_REJECT`: the spurious ID is returned.

The next state depends only on the current strobe, whatever the present state:
- strobe with an acceptable interrupt goes to `ST_GRANT`;
- strobe with a spurious or unacceptable interrupt goes to `ST_REJECT`;
- no strobe goes to `ST_IDLE`.

Top module: `irq_ack_unit`

## Requirements
- R1: When the current ID is 1023, or any other value not below NUM_IRQ, the acknowledge returns 1023. It raises neither update strobe and changes no state.
- R2: When the selected interrupt's 8-bit priority is greater than or equal to the 9-bit running priority, the acknowledge returns 1023 and changes no state.
- R3: For an ID below 16, the lowest-numbered set bit of that ID's source mask is chosen and cleared. If the mask is empty, source 0 is reported.
- R4: For an ID below 16, `pend_clr_o` is raised only when no source bit remains for that ID after the acknowledge, counting a post to the same ID in the same cycle.
- R5: The returned value carries the ID in bits 9:0. For IDs below 16 it carries the chosen source number in bits 12:10; otherwise bits 12:10 are zero.
- R6: For an accepted ID of 16 or above, `pend_clr_o` is always raised; the unit takes no trigger-mode input.
- R7: The group priority is the priority ANDed with all-ones shifted left by (bp mod 8) + 1. The value bp = 7 therefore gives a group priority of 0.
- R8: bp is the aliased binary point minus one, wrapping in 3 bits, when `groups_on_i` is 1, `cbpr_i` is 0 and the interrupt's group bit is 1. Otherwise bp is `bpr_i`.
- R9: On acceptance the running priority becomes the group priority, and `act_set_o` is raised with `upd_id_o` equal to the ID. The bit at level = group priority >> 1 is set, at word level/32 and bit level%32 of the flat APR vector. It goes to the non-secure bank when `groups_on_i` and the group bit are both 1, and to the secure bank otherwise.
- R10: Every result and state change appears in the cycle after the strobe. `ack_valid_o` is high in exactly the cycles following a strobe.
- R11: After reset the running priority is 0x100, both APR banks are zero, all source masks are zero and no response is valid.
- R12: A post sets bit src of the source mask of SGI id. A post and an acknowledge to the same SGI in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| ack_req_i | input | 1 | acknowledge read strobe |
| cur_id_i | input | 10 | ID chosen by the selector |
| prio_i | input | 512 | priority of each interrupt, 8 bits per ID |
| group_i | input | 64 | group bit of each interrupt |
| groups_on_i | input | 1 | interrupt grouping in use |
| cbpr_i | input | 1 | shared binary point control |
| bpr_i | input | 3 | normal binary point |
| abpr_i | input | 3 | aliased binary point |
| sgi_post_i | input | 1 | record a software interrupt source |
| sgi_post_id_i | input | 4 | SGI ID being posted |
| sgi_post_src_i | input | 3 | source CPU number |
| ack_valid_o | output | 1 | response valid |
| ack_data_o | output | 13 | returned ID and source |
| pend_clr_o | output | 1 | clear pending for `upd_id_o` |
| act_set_o | output | 1 | set active for `upd_id_o` |
| upd_id_o | output | 10 | ID of the update strobes |
| run_prio_o | output | 9 | running priority |
| apr_sec_o | output | 128 | secure active-priority bank |
| apr_nsec_o | output | 128 | non-secure active-priority bank |
| sgi_src_o | output | 128 | source masks, 8 bits per SGI |

## Verification
All results are registered once, so every result is due in the single cycle after the clock edge that captures the strobe. This covers the response data, the update strobes, the running priority, the APR banks and the source masks. The bench drives the strobe at one falling edge and removes it at the next. It reads every output at that second falling edge, which lies inside the response cycle. One further falling edge then shows that the response has lapsed.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam int SRCF_W = 3;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REJECT = 2'd2
    } ack_state_e;
endpackage

// File: rtl/irq_ack_grp_prio.sv
module irq_ack_grp_prio #(
    parameter int PRIO_W = 8,
    localparam int LVL_W = PRIO_W - 1,
    localparam int APR_WORDS = (1 << LVL_W) / 32,
    localparam int WIDX_W = (APR_WORDS > 1) ? $clog2(APR_WORDS) : 1
) (
    input  logic [PRIO_W-1:0] prio_i,
    input  logic              alias_i,
    input  logic [2:0]        bpr_i,
    input  logic [2:0]        abpr_i,
    output logic [PRIO_W-1:0] gprio_o,
    output logic [WIDX_W-1:0] word_o,
    output logic [4:0]        bit_o
);
    logic [2:0]        bp;
    logic [3:0]        shamt;
    logic [PRIO_W:0]   wide_mask;
    logic [LVL_W-1:0]  level;

    always_comb begin
        bp        = alias_i ? (abpr_i - 3'd1) : bpr_i;
        shamt     = {1'b0, bp} + 4'd1;
        wide_mask = {(PRIO_W+1){1'b1}} << shamt;
        gprio_o   = prio_i & wide_mask[PRIO_W-1:0];
        level     = gprio_o[PRIO_W-1:1];
        word_o    = WIDX_W'(level >> 5);
        bit_o     = level[4:0];
    end
endmodule

// File: rtl/irq_ack_sgi_track.sv
module irq_ack_sgi_track #(
    parameter int NUM_SGI = 16,
    parameter int SRC_N = 8,
    localparam int SGI_IW = $clog2(NUM_SGI),
    localparam int SRC_W = $clog2(SRC_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     post_i,
    input  logic [SGI_IW-1:0]        post_id_i,
    input  logic [SRC_W-1:0]         post_src_i,
    input  logic                     take_i,
    input  logic [SGI_IW-1:0]        take_id_i,
    output logic [SRC_W-1:0]         pick_src_o,
    output logic                     drained_o,
    output logic [NUM_SGI*SRC_N-1:0] masks_o
);
    logic [SRC_N-1:0] mask_q [NUM_SGI];
    logic [SRC_N-1:0] cur_mask;
    logic [SRC_N-1:0] pick_bit;
    logic [SRC_N-1:0] post_bit;

    always_comb begin
        cur_mask   = mask_q[take_id_i];
        pick_bit   = cur_mask & (~cur_mask + SRC_N'(1));
        pick_src_o = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (cur_mask[i]) pick_src_o = SRC_W'(i);
        end
        post_bit  = (post_i && post_id_i == take_id_i) ? (SRC_N'(1) << post_src_i) : '0;
        drained_o = ((cur_mask & ~pick_bit) | post_bit) == '0;
    end

    for (genvar g = 0; g < NUM_SGI; g++) begin : g_sgi
        logic [SRC_N-1:0] clr_here;
        logic [SRC_N-1:0] set_here;
        assign clr_here = (take_i && take_id_i == SGI_IW'(g)) ? pick_bit : '0;
        assign set_here = (post_i && post_id_i == SGI_IW'(g)) ? (SRC_N'(1) << post_src_i) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[g] <= '0;
            else        mask_q[g] <= (mask_q[g] & ~clr_here) | set_here;
        end
        assign masks_o[g*SRC_N +: SRC_N] = mask_q[g];
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W = 8,
    parameter int NUM_SGI = 16,
    parameter int SRC_N = 8,
    localparam int IDX_W = $clog2(NUM_IRQ),
    localparam int SGI_IW = $clog2(NUM_SGI),
    localparam int SRC_W = $clog2(SRC_N),
    localparam int APR_WORDS = (1 << (PRIO_W - 1)) / 32,
    localparam int WIDX_W = (APR_WORDS > 1) ? $clog2(APR_WORDS) : 1,
    localparam int DATA_W = ID_W + SRCF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req_i,
    input  logic [ID_W-1:0]           cur_id_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [NUM_IRQ-1:0]        group_i,
    input  logic                      groups_on_i,
    input  logic                      cbpr_i,
    input  logic [2:0]                bpr_i,
    input  logic [2:0]                abpr_i,
    input  logic                      sgi_post_i,
    input  logic [SGI_IW-1:0]         sgi_post_id_i,
    input  logic [SRC_W-1:0]          sgi_post_src_i,
    output logic                      ack_valid_o,
    output logic [DATA_W-1:0]         ack_data_o,
    output logic                      pend_clr_o,
    output logic                      act_set_o,
    output logic [ID_W-1:0]           upd_id_o,
    output logic [PRIO_W:0]           run_prio_o,
    output logic [APR_WORDS*32-1:0]   apr_sec_o,
    output logic [APR_WORDS*32-1:0]   apr_nsec_o,
    output logic [NUM_SGI*SRC_N-1:0]  sgi_src_o
);
    ack_state_e state_q, state_d;

    logic [IDX_W-1:0]   idx;
    logic               id_ok, is_sgi, cur_grp, use_ns, accept;
    logic [PRIO_W-1:0]  cur_prio, gprio;
    logic [WIDX_W-1:0]  apr_word;
    logic [4:0]         apr_bit;
    logic [SRC_W-1:0]   pick_src;
    logic               drained;
    logic [DATA_W-1:0]  ret_val;

    logic [DATA_W-1:0]  data_q;
    logic               pend_q;
    logic [ID_W-1:0]    id_q;
    logic [PRIO_W:0]    run_prio_q;
    logic [APR_WORDS-1:0][31:0] apr_s_q, apr_ns_q;

    // selection and acceptance
    always_comb begin
        id_ok    = cur_id_i < ID_W'(NUM_IRQ);
        idx      = cur_id_i[IDX_W-1:0];
        cur_prio = prio_i[int'(idx)*PRIO_W +: PRIO_W];
        cur_grp  = group_i[idx];
        use_ns   = groups_on_i & cur_grp;
        is_sgi   = cur_id_i < ID_W'(NUM_SGI);
        accept   = ack_req_i & id_ok & ({1'b0, cur_prio} < run_prio_q);
        ret_val  = is_sgi ? {SRCF_W'(pick_src), cur_id_i} : {SRCF_W'(0), cur_id_i};
    end

    irq_ack_grp_prio #(.PRIO_W(PRIO_W)) u_gprio (
        .prio_i  (cur_prio),
        .alias_i (use_ns & ~cbpr_i),
        .bpr_i   (bpr_i),
        .abpr_i  (abpr_i),
        .gprio_o (gprio),
        .word_o  (apr_word),
        .bit_o   (apr_bit)
    );

    irq_ack_sgi_track #(.NUM_SGI(NUM_SGI), .SRC_N(SRC_N)) u_sgi (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_i     (sgi_post_i),
        .post_id_i  (sgi_post_id_i),
        .post_src_i (sgi_post_src_i),
        .take_i     (accept & is_sgi),
        .take_id_i  (cur_id_i[SGI_IW-1:0]),
        .pick_src_o (pick_src),
        .drained_o  (drained),
        .masks_o    (sgi_src_o)
    );

    // next state: depends only on the strobe and its verdict
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_REJECT:
                state_d = !ack_req_i ? ST_IDLE : (accept ? ST_GRANT : ST_REJECT);
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // activation state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            pend_q     <= 1'b0;
            id_q       <= '0;
            run_prio_q <= {1'b1, {PRIO_W{1'b0}}};
            apr_s_q    <= '0;
            apr_ns_q   <= '0;
        end else if (accept) begin
            data_q     <= ret_val;
            pend_q     <= is_sgi ? drained : 1'b1;
            id_q       <= cur_id_i;
            run_prio_q <= {1'b0, gprio};
            if (use_ns) apr_ns_q[apr_word][apr_bit] <= 1'b1;
            else        apr_s_q[apr_word][apr_bit]  <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            ST_GRANT: begin
                ack_valid_o = 1'b1;
                ack_data_o  = data_q;
                act_set_o   = 1'b1;
                pend_clr_o  = pend_q;
                upd_id_o    = id_q;
            end
            ST_REJECT: begin
                ack_valid_o = 1'b1;
                ack_data_o  = DATA_W'(SPURIOUS_ID);
                act_set_o   = 1'b0;
                pend_clr_o  = 1'b0;
                upd_id_o    = '0;
            end
            default: begin
                ack_valid_o = 1'b0;
                ack_data_o  = '0;
                act_set_o   = 1'b0;
                pend_clr_o  = 1'b0;
                upd_id_o    = '0;
            end
        endcase
    end

    assign run_prio_o = run_prio_q;
    assign apr_sec_o  = apr_s_q;
    assign apr_nsec_o = apr_ns_q;
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
    parameter int PRIO_W = 8,
    parameter int APR_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ack_req_i,
    input logic [9:0]          cur_id_i,
    input logic                ack_valid_o,
    input logic [12:0]         ack_data_o,
    input logic                pend_clr_o,
    input logic                act_set_o,
    input logic [PRIO_W:0]     run_prio_o,
    input logic [APR_BITS-1:0] apr_sec_o,
    input logic [APR_BITS-1:0] apr_nsec_o
);
    a_r1_spurious_id: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_i && cur_id_i == 10'd1023) |=>
            (ack_valid_o && ack_data_o == 13'd1023 && !act_set_o && !pend_clr_o));

    a_r2_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && ack_data_o == 13'd1023) |->
            (!act_set_o && !pend_clr_o && $stable(run_prio_o)
             && $stable(apr_sec_o) && $stable(apr_nsec_o)));

    a_r9_prio_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        act_set_o |-> (run_prio_o < $past(run_prio_o)));

    a_r9_apr_marked: assert property (@(posedge clk) disable iff (!rst_n)
        act_set_o |-> ((apr_sec_o | apr_nsec_o) != '0));

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_i |=> ack_valid_o);

    a_r10_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req_i |=> !ack_valid_o);

    a_r4_pend_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_o |-> (act_set_o && ack_valid_o));
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.PRIO_W(PRIO_W), .APR_BITS(APR_WORDS*32)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req_i   (ack_req_i),
    .cur_id_i    (cur_id_i),
    .ack_valid_o (ack_valid_o),
    .ack_data_o  (ack_data_o),
    .pend_clr_o  (pend_clr_o),
    .act_set_o   (act_set_o),
    .run_prio_o  (run_prio_o),
    .apr_sec_o   (apr_sec_o),
    .apr_nsec_o  (apr_nsec_o)
);

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         ack_req = 0;
    logic [9:0]   cur_id = 0;
    logic [511:0] prio_v = '1;
    logic [63:0]  group_v = '0;
    logic         gen = 0, cbpr = 0;
    logic [2:0]   bpr = 0, abpr = 0;
    logic         sgi_post = 0;
    logic [3:0]   post_id = 0;
    logic [2:0]   post_src = 0;

    logic         ack_valid, pend_clr, act_set;
    logic [12:0]  ack_data;
    logic [9:0]   upd_id;
    logic [8:0]   run_prio;
    logic [127:0] apr_s, apr_ns, sgi_src;

    irq_ack_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ack_req_i(ack_req), .cur_id_i(cur_id),
        .prio_i(prio_v), .group_i(group_v), .groups_on_i(gen), .cbpr_i(cbpr),
        .bpr_i(bpr), .abpr_i(abpr), .sgi_post_i(sgi_post), .sgi_post_id_i(post_id),
        .sgi_post_src_i(post_src), .ack_valid_o(ack_valid), .ack_data_o(ack_data),
        .pend_clr_o(pend_clr), .act_set_o(act_set), .upd_id_o(upd_id),
        .run_prio_o(run_prio), .apr_sec_o(apr_s), .apr_nsec_o(apr_ns),
        .sgi_src_o(sgi_src)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_ack(input int id, input bit post, input int pid, input int psrc);
        @(negedge clk);
        cur_id = 10'(id); ack_req = 1;
        sgi_post = post; post_id = 4'(pid); post_src = 3'(psrc);
        @(negedge clk);
        ack_req = 0; sgi_post = 0;
    endtask

    task automatic do_post(input int pid, input int psrc);
        @(negedge clk);
        sgi_post = 1; post_id = 4'(pid); post_src = 3'(psrc);
        @(negedge clk);
        sgi_post = 0;
    endtask

    typedef struct packed {
        logic [9:0]  id;
        logic [7:0]  prio;
        logic        grp, gen, cbpr;
        logic [2:0]  bpr, abpr;
        logic [12:0] edata;
        logic [8:0]  erp;
        logic        acc, ens;
        logic [1:0]  eword;
        logic [4:0]  ebit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'd40,   8'hA5, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 13'd40,   9'h0A0, 1'b1, 1'b0, 2'd2, 5'd16},
        '{10'd33,   8'h37, 1'b1, 1'b1, 1'b0, 3'd0, 3'd3, 13'd33,   9'h030, 1'b1, 1'b1, 2'd0, 5'd24},
        '{10'd33,   8'h37, 1'b1, 1'b1, 1'b1, 3'd0, 3'd3, 13'd33,   9'h036, 1'b1, 1'b1, 2'd0, 5'd27},
        '{10'd20,   8'hFF, 1'b0, 1'b1, 1'b0, 3'd7, 3'd0, 13'd20,   9'h000, 1'b1, 1'b0, 2'd0, 5'd0},
        '{10'd1023, 8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 13'd1023, 9'h100, 1'b0, 1'b0, 2'd0, 5'd0},
        '{10'd70,   8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 13'd1023, 9'h100, 1'b0, 1'b0, 2'd0, 5'd0},
        '{10'd50,   8'hC9, 1'b1, 1'b0, 1'b0, 3'd4, 3'd1, 13'd50,   9'h0C0, 1'b1, 1'b0, 2'd3, 5'd0},
        '{10'd63,   8'h9B, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 13'd63,   9'h000, 1'b1, 1'b1, 2'd0, 5'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        @(negedge clk);
        check("R11", "valid", 128'(ack_valid), 128'd0);
        check("R11", "run prio", 128'(run_prio), 128'h100);
        check("R11", "apr", apr_s | apr_ns, 128'd0);
        check("R11", "sgi masks", sgi_src, 128'd0);

        // table walk: R1 R2 R6 R7 R8 R9
        for (int v = 0; v < 8; v++) begin
            logic [127:0] e;
            do_reset();
            gen = VECS[v].gen; cbpr = VECS[v].cbpr;
            bpr = VECS[v].bpr; abpr = VECS[v].abpr;
            if (VECS[v].id < 64) begin
                prio_v[int'(VECS[v].id)*8 +: 8] = VECS[v].prio;
                group_v[VECS[v].id[5:0]] = VECS[v].grp;
            end
            do_ack(int'(VECS[v].id), 0, 0, 0);
            e = VECS[v].acc ? (128'd1 << (int'(VECS[v].eword)*32 + int'(VECS[v].ebit))) : 128'd0;
            check("R1/R9", "data", 128'(ack_data), 128'(VECS[v].edata));
            check("R9", "act_set", 128'(act_set), 128'(VECS[v].acc));
            check("R6", "pend_clr", 128'(pend_clr), 128'(VECS[v].acc));
            check("R9", "upd_id", 128'(upd_id), VECS[v].acc ? 128'(VECS[v].id) : 128'd0);
            check("R7/R8", "run prio", 128'(run_prio), 128'(VECS[v].erp));
            check("R9", "apr ns", apr_ns, VECS[v].ens ? e : 128'd0);
            check("R9", "apr s", apr_s, VECS[v].ens ? 128'd0 : e);
            @(negedge clk);
            check("R10", "valid lapses", 128'(ack_valid), 128'd0);
            prio_v = '1; group_v = '0;
        end

        // R2 priority against running priority
        do_reset();
        gen = 0; cbpr = 0; bpr = 0;
        prio_v[40*8 +: 8] = 8'h80; prio_v[41*8 +: 8] = 8'h80; prio_v[42*8 +: 8] = 8'h7F;
        do_ack(40, 0, 0, 0);
        check("R2", "first rp", 128'(run_prio), 128'h080);
        do_ack(41, 0, 0, 0);
        check("R2", "equal prio data", 128'(ack_data), 128'd1023);
        check("R2", "equal prio act", 128'(act_set), 128'd0);
        check("R2", "rp kept", 128'(run_prio), 128'h080);
        do_ack(42, 0, 0, 0);
        check("R2", "higher prio data", 128'(ack_data), 128'd42);
        check("R2", "higher prio rp", 128'(run_prio), 128'h07E);

        // R3 R4 R5 R12 software interrupts
        do_reset();
        do_post(5, 3);
        do_post(5, 6);
        check("R12", "mask after posts", 128'(sgi_src[5*8 +: 8]), 128'h48);
        prio_v[5*8 +: 8] = 8'h10;
        do_ack(5, 0, 0, 0);
        check("R5", "sgi data src3", 128'(ack_data), 128'h0C05);
        check("R4", "no pend clr", 128'(pend_clr), 128'd0);
        check("R3", "lowest cleared", 128'(sgi_src[5*8 +: 8]), 128'h40);
        prio_v[5*8 +: 8] = 8'h08;
        do_ack(5, 0, 0, 0);
        check("R5", "sgi data src6", 128'(ack_data), 128'h1805);
        check("R4", "pend clr drained", 128'(pend_clr), 128'd1);
        check("R3", "mask empty", 128'(sgi_src[5*8 +: 8]), 128'h00);
        prio_v[9*8 +: 8] = 8'h04;
        do_ack(9, 0, 0, 0);
        check("R3", "empty mask src0", 128'(ack_data), 128'd9);
        check("R4", "empty mask pend", 128'(pend_clr), 128'd1);

        // R12 simultaneous post and acknowledge
        do_reset();
        do_post(7, 2);
        prio_v[7*8 +: 8] = 8'h20;
        do_ack(7, 1, 7, 4);
        check("R12", "simul data", 128'(ack_data), 128'h0807);
        check("R12", "simul no pend clr", 128'(pend_clr), 128'd0);
        check("R12", "simul mask", 128'(sgi_src[7*8 +: 8]), 128'h10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule